// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave on I2C

This block is the serial configuration port of a clock generator. It listens on a two-wire I2C bus in standard mode, answers to one fixed 7-bit device address, and keeps six 8-bit control bytes. The clock-control logic reads these bytes in parallel, with byte k on bits `[8k+7:8k]` of `cfg_o`. Both bus lines are sampled by the system clock, so the system clock must run well above the bus bit rate. SDA is driven in open-drain fashion: `sda_oe_o` high means the pad pulls SDA low.

The only transfers are block transfers, and they always begin at byte 0. A write carries two leading bytes (a command code and a byte count) that the slave acknowledges and then throws away. The data bytes follow and fill the bank in order. A read returns a byte count first and then the bank contents in order. A transfer has no register pointer, the slave never stretches the clock, and a transfer can be cut short after any whole byte.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, `cfg_o` holds byte0=0x0F, byte1=0xFF, byte2=0xFF, byte3=0x00, byte4=0x00 and byte5=0x06. Byte k sits on bits [8k+7:8k].
- R2: The device answers to 7-bit address 0x69. The address byte is MSB first, with the R/W flag in its LSB, so 0xD2 selects a write and 0xD3 a read. The slave acknowledges either one by pulling SDA low during the ninth clock.
- R3: Any other address byte gets no acknowledge. The slave then drives nothing and ignores later bytes until the next START, and the registers keep their values.
- R4: In a write, the slave acknowledges the first two bytes after the address and ignores their contents. `cfg_o` does not change because of them.
- R5: The third and later bytes of a write go into byte 0, byte 1 and onward up to byte 5, in that order. Each one is acknowledged and shows on `cfg_o` once it is complete.
- R6: A STOP after a whole byte ends the write, and bytes not yet reached keep their values. A byte cut off by STOP or START before its eighth bit is dropped.
- R7: The slave acknowledges write data past byte 5 and discards it.
- R8: A read returns the count 0x06 first, then bytes 0 to 5, each MSB first. Every byte requested after byte 5 reads as 0xFF (SDA released).
- R9: When the master does not acknowledge a read byte, the slave releases SDA. It stays silent until the next START.
- R10: A repeated START at any point aborts the transfer in progress and restarts address reception. The next write starts again at byte 0.
- R11: SCL and SDA each pass through a two-flop synchroniser. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. `sda_oe_o` changes only after an SCL fall, except that START and STOP force it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_o | output | NUM_REGS*8 | Configuration bank, byte k on bits [8k+7:8k] |

## Verification
The bench sweeps all 256 address bytes. A slave that decodes the R/W flag into its match, or that acknowledges a near-miss address, shows up as a wrong acknowledge or as a byte written while it should be ignoring the bus. Writes of every length from zero to six data bytes, and one that overruns the bank, catch an off-by-two in the skipping of the command and count bytes, a pointer that wraps into byte 0, and a slave that refuses extra bytes. A write that is cut off mid-byte by STOP or by a repeated START must leave the bank unchanged and send the next write back to byte 0; a design that commits partial shifts or keeps its pointer fails here. Reads check the leading count, bit order and the released line after a NACK, which a slave that keeps shifting would corrupt.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } xfer_state_e;

  // Power-on contents of each configuration byte
  function automatic logic [BYTE_W-1:0] reg_reset_value(input int unsigned idx);
    logic [BYTE_W-1:0] v;
    case (idx)
      0:       v = 8'h0F;
      1, 2:    v = 8'hFF;
      5:       v = 8'h06;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_now;
  logic              sda_now;

  assign scl_now = scl_pipe[LAST];
  assign sda_now = sda_pipe[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe  <= '1;
      sda_pipe  <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      sda_lvl   <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_pipe  <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe  <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q     <= scl_now;
      sda_q     <= sda_now;
      sda_lvl   <= sda_now;
      scl_rise  <= ~scl_q & scl_now;
      scl_fall  <= scl_q & ~scl_now;
      start_det <= scl_q & scl_now & sda_q & ~sda_now;
      stop_det  <= scl_q & scl_now & ~sda_q & sda_now;
    end
  end

endmodule

// File: rtl/i2c_cfg_xfer.sv
module i2c_cfg_xfer
  import clkcfg_pkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sda_lvl,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       start_det,
  input  logic                       stop_det,
  input  logic [NUM_REGS*BYTE_W-1:0] rd_data,
  output logic                       sda_oe,
  output logic                       wr_en,
  output logic [$clog2(NUM_REGS)-1:0] wr_idx,
  output logic [BYTE_W-1:0]          wr_data
);

  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int WPOS_W    = $clog2(NUM_REGS + 3);
  localparam int RPOS_W    = $clog2(NUM_REGS + 2);

  localparam logic [WPOS_W-1:0] WR_FIRST  = WPOS_W'(2);
  localparam logic [WPOS_W-1:0] WR_END    = WPOS_W'(NUM_REGS + 2);
  localparam logic [RPOS_W-1:0] RD_LAST   = RPOS_W'(NUM_REGS + 1);
  localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);

  xfer_state_e         state;
  logic [3:0]          bit_cnt;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   txreg;
  logic                rw_q;
  logic                mack_q;
  logic [WPOS_W-1:0]   wr_pos;
  logic [RPOS_W-1:0]   rd_pos;
  logic [RPOS_W-1:0]   rd_next;
  logic [BYTE_W-1:0]   tx_sel;
  logic                oe_q;

  assign sda_oe = oe_q;

  // Next read position saturates one past the bank (returns released line)
  assign rd_next = (rd_pos == RD_LAST) ? rd_pos : rd_pos + RPOS_W'(1);

  always_comb begin
    tx_sel = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_next == RPOS_W'(k + 1)) tx_sel = rd_data[k*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= 4'd0;
      shreg   <= '0;
      txreg   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      wr_pos  <= '0;
      rd_pos  <= '0;
      oe_q    <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= 4'd0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= 4'd0;
              if (shreg[7:1] == DEV_ADDR) begin
                state <= ST_ADDR_ACK;
                oe_q  <= 1'b1;
                rw_q  <= shreg[0];
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                state  <= ST_RD;
                rd_pos <= '0;
                txreg  <= COUNT_BYTE;
                oe_q   <= ~COUNT_BYTE[7];
              end else begin
                state  <= ST_WR;
                wr_pos <= '0;
                oe_q   <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= 4'd0;
              oe_q    <= 1'b1;
              state   <= ST_WR_ACK;
              if (wr_pos >= WR_FIRST && wr_pos < WR_END) begin
                wr_en   <= 1'b1;
                wr_idx  <= REG_IDX_W'(wr_pos - WR_FIRST);
                wr_data <= shreg;
              end
              if (wr_pos != WR_END) wr_pos <= wr_pos + WPOS_W'(1);
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              state <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                bit_cnt <= 4'd0;
                oe_q    <= 1'b0;
                state   <= ST_RD_ACK;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                txreg   <= {txreg[BYTE_W-2:0], 1'b0};
                oe_q    <= ~txreg[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                rd_pos <= rd_next;
                txreg  <= tx_sel;
                oe_q   <= ~tx_sel[7];
                state  <= ST_RD;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !oe_q); // R11

  AST_OE_ON_SCL_FALL: assert property (@(posedge clk) disable iff (rst)
    (oe_q != $past(oe_q)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R11

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> !oe_q); // R9

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [NUM_REGS*BYTE_W-1:0]  cfg_o
);

  localparam int                    REG_IDX_W = $clog2(NUM_REGS);
  localparam logic [REG_IDX_W-1:0]  LAST_IDX  = REG_IDX_W'(NUM_REGS - 1);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= reg_reset_value(g);
      end else if (wr_en && wr_idx == REG_IDX_W'(g)) begin
        byte_q <= wr_data;
      end
    end
    assign cfg_o[g*BYTE_W +: BYTE_W] = byte_q;
  end

  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx <= LAST_IDX)); // R7

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_o)); // R6

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  localparam int REG_IDX_W = $clog2(NUM_REGS);

  logic                 sda_lvl;
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 start_det;
  logic                 stop_det;
  logic                 wr_en;
  logic [REG_IDX_W-1:0] wr_idx;
  logic [BYTE_W-1:0]    wr_data;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_cfg_xfer #(
    .NUM_REGS(NUM_REGS),
    .DEV_ADDR(DEV_ADDR)
  ) xfer_i (
    .clk      (clk),
    .rst      (rst),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (cfg_o),
    .sda_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  cfg_reg_bank #(
    .NUM_REGS(NUM_REGS)
  ) bank_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .cfg_o  (cfg_o)
  );

endmodule

// File: tb/clkcfg_i2c_slave_tb_top.sv
module clkcfg_i2c_slave_tb_top;

  localparam int Q        = 6;
  localparam int NREG     = 6;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg;
  logic bus_sda;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_b [NREG];

  assign bus_sda = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  clkcfg_i2c_slave dut_i (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl),
    .sda_i   (bus_sda),
    .sda_oe_o(sda_oe),
    .cfg_o   (cfg)
  );

  function automatic logic [NREG*8-1:0] exp_flat();
    logic [NREG*8-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*8 +: 8] = exp_b[k];
    return f;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [NREG*8-1:0] act,
                     input logic [NREG*8-1:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = !bus_sda; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic read_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b = {b[6:0], bus_sda}; tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // Address plus the two ignored header bytes of a write
  task automatic write_header(input string tag);
    bit a;
    write_byte(8'hD2, a); chk(a, {tag, " R2 write address ack"}, a, 1);
    write_byte(8'h5A, a); chk(a, {tag, " R4 command ack"}, a, 1);
    write_byte(8'h33, a); chk(a, {tag, " R4 count ack"}, a, 1);
  endtask

  task automatic check_bank(input string tag);
    chk(cfg === exp_flat(), tag, cfg, exp_flat());
  endtask

  task automatic stop_and_release(input string tag);
    bus_stop();
    tick(2);
    chk(sda_oe == 1'b0, {tag, " R11 released after STOP"}, sda_oe, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all requirements actual=%0d cycles expected=finish", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] rb;
    exp_b[0] = 8'h0F; exp_b[1] = 8'hFF; exp_b[2] = 8'hFF;
    exp_b[3] = 8'h00; exp_b[4] = 8'h00; exp_b[5] = 8'h06;
    tick(5);
    rst = 1'b0;
    tick(5);

    // R1 reset contents
    check_bank("R1 reset bank");
    chk(sda_oe == 1'b0, "R1 idle line released", sda_oe, 0);

    // R4 / R5 full block write
    bus_start();
    write_header("full");
    check_bank("R4 header bytes leave bank unchanged");
    for (int k = 0; k < NREG; k++) begin
      exp_b[k] = 8'h3C ^ 8'(k * 37);
      write_byte(exp_b[k], a);
      chk(a, "R5 data byte ack", a, 1);
    end
    stop_and_release("full");
    check_bank("R5 full write stored in order");

    // R6 writes of every length 0..6
    for (int n = 0; n <= NREG; n++) begin
      bus_start();
      write_header("len");
      for (int k = 0; k < n; k++) begin
        exp_b[k] = 8'(n * 16 + k * 7 + 1);
        write_byte(exp_b[k], a);
        chk(a, "R5 short write ack", a, 1);
      end
      stop_and_release("len");
      check_bank("R6 short write keeps unreached bytes");
    end

    // R7 overrun past byte 5
    bus_start();
    write_header("over");
    for (int k = 0; k < NREG + 3; k++) begin
      logic [7:0] v;
      v = 8'hC1 + 8'(k * 11);
      if (k < NREG) exp_b[k] = v;
      write_byte(v, a);
      chk(a, "R7 overrun byte ack", a, 1);
    end
    stop_and_release("over");
    check_bank("R7 overrun bytes discarded");

    // R8 block read
    bus_start();
    write_byte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    read_byte(rb, 1'b1);
    chk(rb == 8'h06, "R8 byte count", rb, 8'h06);
    for (int k = 0; k < NREG; k++) begin
      read_byte(rb, 1'b1);
      chk(rb == exp_b[k], "R8 read data", rb, exp_b[k]);
    end
    read_byte(rb, 1'b1);
    chk(rb == 8'hFF, "R8 read past bank", rb, 8'hFF);
    read_byte(rb, 1'b0);
    chk(rb == 8'hFF, "R8 read past bank again", rb, 8'hFF);
    stop_and_release("read");
    check_bank("R8 read leaves bank intact");

    // R9 NACK on the count byte, then slave stays silent
    bus_start();
    write_byte(8'hD3, a); chk(a, "R9 read address ack", a, 1);
    read_byte(rb, 1'b0);
    chk(rb == 8'h06, "R9 count before NACK", rb, 8'h06);
    read_byte(rb, 1'b0);
    chk(rb == 8'hFF, "R9 silent after NACK", rb, 8'hFF);
    stop_and_release("nack");

    // R6 byte cut off by STOP is dropped
    bus_start();
    write_header("cut");
    send_bits(8'h00, 5);
    stop_and_release("cut");
    check_bank("R6 partial byte before STOP dropped");

    // R10 repeated START mid-byte, then new write restarts at byte 0
    bus_start();
    write_header("rs1");
    exp_b[0] = 8'hA5;
    write_byte(8'hA5, a); chk(a, "R10 first data ack", a, 1);
    send_bits(8'h00, 3);
    bus_start();
    write_header("rs2");
    exp_b[0] = 8'h96;
    write_byte(8'h96, a); chk(a, "R10 data after restart ack", a, 1);
    stop_and_release("rs");
    check_bank("R10 restart begins at byte 0, partial byte dropped");

    // R10 repeated START from write header into a read
    bus_start();
    write_byte(8'hD2, a); chk(a, "R10 write address ack", a, 1);
    write_byte(8'h01, a); chk(a, "R10 command ack", a, 1);
    bus_start();
    write_byte(8'hD3, a); chk(a, "R10 read after restart ack", a, 1);
    read_byte(rb, 1'b1);
    chk(rb == 8'h06, "R10 count after restart", rb, 8'h06);
    read_byte(rb, 1'b0);
    chk(rb == exp_b[0], "R10 byte0 after restart", rb, exp_b[0]);
    stop_and_release("rsr");

    // R2 / R3 sweep of every address byte
    for (int adr = 0; adr < 256; adr++) begin
      bit want;
      want = (adr == 8'hD2) || (adr == 8'hD3);
      bus_start();
      write_byte(8'(adr), a);
      chk(a == want, want ? "R2 address sweep ack" : "R3 address sweep nack", a, want);
      if (adr == 8'hD3) begin
        read_byte(rb, 1'b0);
      end else if (!want && (adr % 32) == 5) begin
        write_byte(8'h00, a);
        chk(a == 1'b0, "R3 byte after foreign address not acked", a, 0);
      end
      bus_stop();
    end
    tick(2);
    check_bank("R3 foreign addresses leave bank intact");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule